// File: doc/BRIEF.md
# Step Input Conditioner

This block sits between an asynchronous step-clock pin and a motor phase sequencer. It brings the pin and its companion control pins into the system clock domain and removes short spikes from the step pin. It then turns each accepted transition into a single-cycle step strobe. A select pin chooses what counts as a step: rising transitions only, or transitions in both directions. When both directions count, one input period gives two steps.

When a transition is accepted, the block also stores the direction pin, the excitation-mode pins and the edge-select pin in holding registers. These values are presented alongside the strobe. The sequencer therefore sees a direction and mode that belong to that step. Pin changes between steps have no effect until the next accepted transition.

A low enable freezes the conditioner. No strobe is produced, the held values do not move, and no pin activity changes internal state. Only the synchronous reset still acts. A transition is accepted only after the synchronized pin has held its new level for a parameterised number of system clocks. That number is set below the shortest legal pulse width.

Top module: `step_edge_conditioner`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `step_stb`, `step_dir`, `step_both` and every bit of `step_mode` are 0.
- R2: With `edge_both_pin` = 0, each accepted low-to-high transition of `step_pin` gives one strobe, and high-to-low transitions give none.
- R3: With `edge_both_pin` = 1, each accepted transition of `step_pin` gives one strobe, whatever its direction.
- R4: A transition of `step_pin` from a settled level raises `step_stb` exactly STABLE_CYCLES+3 clock cycles later (two synchronizer stages, the stability count, and the filter and strobe registers).
- R5: A `step_pin` pulse shorter than STABLE_CYCLES system clocks produces no strobe. A pulse of exactly STABLE_CYCLES clocks is accepted.
- R6: `step_stb` is high for exactly one cycle per accepted transition.
- R7: `step_dir` takes the value of `dir_pin` only when a strobe is issued. A change of `dir_pin` between strobes leaves `step_dir` unchanged.
- R8: `step_mode` and `step_both` take the values of `mode_pin` and `edge_both_pin` only when a strobe is issued. A mode change between strobes becomes visible with the next strobe.
- R9: While `en` is low, no strobe is issued, `step_dir`/`step_mode`/`step_both` hold, and toggling `step_pin` or `dir_pin` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | 1 = run, 0 = freeze all state |
| step_pin | input | 1 | Raw asynchronous step clock |
| dir_pin | input | 1 | Raw direction level |
| mode_pin | input | MODE_W | Raw excitation-mode code |
| edge_both_pin | input | 1 | 0 = rising only, 1 = both edges |
| step_stb | output | 1 | One-cycle step strobe |
| step_dir | output | 1 | Direction held at last strobe |
| step_mode | output | MODE_W | Mode held at last strobe |
| step_both | output | 1 | Edge select held at last strobe |

## Verification
The bench measures pulses just under and exactly at the stability count. A filter off by one would either pass a spike or drop a legal pulse. It counts strobes for mixed edge-select settings and toggle counts, which exposes a design that also steps on falling edges in rising-only mode, or that misses them in both-edge mode. It changes direction and mode between strobes, and while disabled, to catch held values that follow the pins freely. It also times the exact strobe latency, so a missing or extra register stage shows up.

// File: rtl/step_cond_pkg.sv
package step_cond_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2
  } edge_kind_e;

  function automatic logic edge_wanted(input edge_kind_e k, input logic both);
    return (k == EDGE_RISE) || (both && (k == EDGE_FALL));
  endfunction

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sc_glitch_filter.sv
module sc_glitch_filter
  import step_cond_pkg::*;
#(
  parameter int STABLE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       s_in,
  output logic       level,
  output edge_kind_e evt
);
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      cnt   <= '0;
      evt   <= EDGE_NONE;
    end else if (!en) begin
      evt <= EDGE_NONE;
    end else begin
      evt <= EDGE_NONE;
      if (s_in != level) begin
        if (cnt == LAST) begin
          level <= s_in;
          cnt   <= '0;
          evt   <= s_in ? EDGE_RISE : EDGE_FALL;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/sc_capture.sv
module sc_capture
  import step_cond_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  edge_kind_e        evt,
  input  logic              dir_live,
  input  logic [MODE_W-1:0] mode_live,
  input  logic              both_live,
  output logic              stb,
  output logic              dir_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              both_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stb    <= 1'b0;
      dir_q  <= 1'b0;
      mode_q <= '0;
      both_q <= 1'b0;
    end else if (!en) begin
      stb <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (edge_wanted(evt, both_live)) begin
        stb    <= 1'b1;
        dir_q  <= dir_live;
        mode_q <= mode_live;
        both_q <= both_live;
      end
    end
  end
endmodule

// File: rtl/step_edge_conditioner.sv
module step_edge_conditioner
  import step_cond_pkg::*;
#(
  parameter int MODE_W        = 2,
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              step_pin,
  input  logic              dir_pin,
  input  logic [MODE_W-1:0] mode_pin,
  input  logic              edge_both_pin,
  output logic              step_stb,
  output logic              step_dir,
  output logic [MODE_W-1:0] step_mode,
  output logic              step_both
);
  localparam int SW = MODE_W + 3;

  logic [SW-1:0] raw_bus, syn_bus;
  logic          s_step, s_dir, s_both;
  logic [MODE_W-1:0] s_mode;
  logic          filt_level;
  edge_kind_e    filt_evt;

  assign raw_bus = {edge_both_pin, mode_pin, dir_pin, step_pin};
  assign s_step  = syn_bus[0];
  assign s_dir   = syn_bus[1];
  assign s_mode  = syn_bus[MODE_W+1:2];
  assign s_both  = syn_bus[SW-1];

  sc_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(syn_bus)
  );

  sc_glitch_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filt (
    .clk(clk), .rst(rst), .en(en), .s_in(s_step),
    .level(filt_level), .evt(filt_evt)
  );

  sc_capture #(.MODE_W(MODE_W)) u_cap (
    .clk(clk), .rst(rst), .en(en), .evt(filt_evt),
    .dir_live(s_dir), .mode_live(s_mode), .both_live(s_both),
    .stb(step_stb), .dir_q(step_dir), .mode_q(step_mode), .both_q(step_both)
  );
endmodule

// File: rtl/step_edge_conditioner_chk.sv
module step_edge_conditioner_chk #(
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              step_stb,
  input logic              step_dir,
  input logic [MODE_W-1:0] step_mode,
  input logic              step_both
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!step_stb && !step_dir && step_mode == '0 && !step_both)); // R1

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    step_stb |=> !step_stb); // R6

  AST_HELD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !step_stb |-> ($stable(step_dir) && $stable(step_mode) && $stable(step_both))); // R7

  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!step_stb && $stable(step_dir) && $stable(step_mode))); // R9

  AST_STB_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    step_stb |-> $past(en)); // R9
endmodule

bind step_edge_conditioner step_edge_conditioner_chk #(.MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .step_stb(step_stb), .step_dir(step_dir),
  .step_mode(step_mode), .step_both(step_both)
);

// File: tb/step_edge_conditioner_bench.sv
module step_edge_conditioner_bench;
  localparam int CLK_P  = 10;
  localparam int MW     = 2;
  localparam int FC     = 8;
  localparam int HALF   = 20;
  localparam int NV     = 5;
  // {both, dir, mode[1:0], toggles[5:0], expected strobes[5:0]}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd1, 6'd4, 6'd2},
    {1'b1, 1'b1, 2'd2, 6'd4, 6'd4},
    {1'b0, 1'b1, 2'd3, 6'd6, 6'd3},
    {1'b1, 1'b0, 2'd0, 6'd2, 6'd2},
    {1'b1, 1'b1, 2'd3, 6'd6, 6'd6}
  };

  logic clk = 0, rst = 1, en = 1, step_pin = 0, dir_pin = 0, edge_both_pin = 0;
  logic [MW-1:0] mode_pin = '0;
  logic step_stb, step_dir, step_both;
  logic [MW-1:0] step_mode;

  int n_chk = 0, n_bad = 0, stb_cnt = 0, run = 0, max_run = 0;

  always #(CLK_P/2) clk = ~clk;

  step_edge_conditioner #(.MODE_W(MW), .STABLE_CYCLES(FC)) u_step_edge_conditioner (
    .clk(clk), .rst(rst), .en(en), .step_pin(step_pin), .dir_pin(dir_pin),
    .mode_pin(mode_pin), .edge_both_pin(edge_both_pin), .step_stb(step_stb),
    .step_dir(step_dir), .step_mode(step_mode), .step_both(step_both)
  );

  always @(negedge clk) begin
    if (step_stb) begin
      stb_cnt++;
      run++;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    int lat;
    idle(5);
    chk("R1 stb", step_stb, 0);
    chk("R1 dir", step_dir, 0);
    chk("R1 mode", step_mode, 0);
    chk("R1 both", step_both, 0);
    rst = 0;
    idle(1);
    chk("R1 after release", {step_stb, step_dir, step_both}, 0);
    idle(20);

    // table walk: R2 rising only, R3 both edges, R7/R8 fields
    for (int v = 0; v < NV; v++) begin
      edge_both_pin = VEC[v][15];
      dir_pin       = VEC[v][14];
      mode_pin      = VEC[v][13:12];
      idle(10);
      stb_cnt = 0;
      for (int t = 0; t < int'(VEC[v][11:6]); t++) begin
        step_pin = ~step_pin;
        idle(HALF);
      end
      idle(30);
      chk(VEC[v][15] ? "R3 count" : "R2 count", stb_cnt, int'(VEC[v][5:0]));
      chk("R7 dir", step_dir, VEC[v][14]);
      chk("R8 mode", step_mode, VEC[v][13:12]);
      chk("R8 both", step_both, VEC[v][15]);
    end

    // R4 latency
    edge_both_pin = 1; idle(10);
    step_pin = 1;
    lat = -1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (step_stb) begin lat = i; break; end
    end
    chk("R4 latency", lat, FC + 3);
    step_pin = 0; idle(40);

    // R5 glitch below threshold and at threshold
    stb_cnt = 0;
    step_pin = 1; idle(FC - 1); step_pin = 0; idle(40);
    chk("R5 short pulse", stb_cnt, 0);
    stb_cnt = 0;
    step_pin = 1; idle(FC); step_pin = 0; idle(40);
    chk("R5 threshold pulse", stb_cnt, 2);
    chk("R6 width", max_run, 1);

    // R7/R8 hold between strobes, take effect on next
    dir_pin = 0; mode_pin = 2'd1; edge_both_pin = 0; idle(10);
    step_pin = 1; idle(HALF); step_pin = 0; idle(HALF);
    dir_pin = 1; mode_pin = 2'd2; idle(30);
    chk("R7 hold dir", step_dir, 0);
    chk("R8 hold mode", step_mode, 1);
    step_pin = 1; idle(HALF); step_pin = 0; idle(HALF);
    chk("R7 new dir", step_dir, 1);
    chk("R8 new mode", step_mode, 2);

    // R9 enable low freezes
    en = 0; stb_cnt = 0;
    dir_pin = 0; mode_pin = 2'd3; edge_both_pin = 1;
    step_pin = 1; idle(HALF); step_pin = 0; idle(HALF);
    step_pin = 1; idle(HALF); step_pin = 0; idle(HALF);
    chk("R9 no strobe", stb_cnt, 0);
    chk("R9 dir held", step_dir, 1);
    chk("R9 mode held", step_mode, 2);
    chk("R9 both held", step_both, 0);
    en = 1; idle(30);
    chk("R9 quiet on resume", stb_cnt, 0);
    step_pin = 1; idle(HALF);
    chk("R9 resumes", stb_cnt, 1);
    chk("R8 resume mode", step_mode, 3);
    step_pin = 0; idle(HALF);

    // R1 reset mid-run
    rst = 1; idle(3);
    chk("R1 rerun", {step_dir, step_mode, step_both}, 0);
    finish_up();
  end
endmodule